// File: doc/BRIEF.md
# Serial Flash Program-Command Shifter

This block runs short, free-form transactions on a serial flash bus. Software fills a small bank of transmit byte registers and a bit-count register, then writes a command code. On the program command the engine asserts chip select and clocks out an opcode followed by transmit bytes, most significant bit first. It keeps clocking until the programmed number of bits has gone by, and it captures the serial input on every rising clock. When chip select releases, the captured bits are copied into a bank of receive bytes that software reads through an index port.

Two fixed shortcuts share the same shifter. One sends a single status byte taken from the opcode register. The other sends the standard read-status opcode and keeps the byte it receives in a dedicated status output. The serial clock runs at a parameterized fraction of the system clock.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset cs_n is 1, sck and mosi are 0, busy is 0, and every receive byte and status_byte read 0.
- R2: Command 0x04 with an effective count n sends n bits MSB first. The bits are taken from the vector {prg5, prg4, prg3, prg2, prg1, prg0, 8'h00}, where prgK is the value written with prg_idx=K. So register 5 is the opcode, and mosi is 0 for every bit past the 48 loaded bits.
- R3: After command 0x04, receive byte K (shreg_idx=K) holds bits 8K+7..8K of the value formed by shifting the n received bits in from the LSB. The last received bit is bit 0 of byte 0, and bits beyond n read 0.
- R4: The effective count is the count register saturated at 56. A count of 0 starts no transaction: busy stays 0, cs_n stays 1 and the receive bytes are unchanged.
- R5: Command 0x20 sends exactly the 8 bits of prg5, whatever the count register holds, and leaves the receive bytes unchanged.
- R6: Command 0x02 sends 16 bits: 8'h05 followed by eight 0 bits. The last 8 bits received appear on status_byte, and the receive bytes are unchanged.
- R7: busy rises on the clock that accepts a command and falls on the clock where cs_n deasserts. Command writes made while busy, and writes of any other code, start nothing.
- R8: cs_n asserts one clock before the first low half of sck and deasserts one clock after the last falling edge of sck. sck is low whenever cs_n is high, and mosi does not change while sck is high.
- R9: A program-data write in the same clock as an accepted command does not affect that transaction. It takes effect from the next command on.
- R10: Each high and each low half of sck lasts SCK_HALF clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prg_we | input | 1 | Write strobe for a transmit byte register |
| prg_idx | input | 3 | Transmit register index (0..5) |
| prg_wdata | input | 8 | Transmit byte value |
| cnt_we | input | 1 | Write strobe for the bit-count register |
| cnt_wdata | input | 8 | Bit count |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code (0x04, 0x20, 0x02) |
| busy | output | 1 | Transaction in progress |
| shreg_idx | input | 3 | Receive byte index (0..6) |
| shreg_data | output | 8 | Selected receive byte |
| status_byte | output | 8 | Byte returned by the last read-status command |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can land on the same clock: a write to a transmit register and the acceptance of a command that snapshots those registers. The bench drives prg_we for register 5 and a write-status command in one cycle, and expects the old byte on the wire. It then repeats the command alone and expects the new byte. A second collision, a command written while busy, is provoked mid-transfer and judged by counting chip-select pulses and checking that status_byte stays unchanged.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] CMD_PROG = 8'h04;
  localparam logic [7:0] CMD_WRSR = 8'h20;
  localparam logic [7:0] CMD_RDSR = 8'h02;

  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_PROG = 2'd1,
    XF_WRSR = 2'd2,
    XF_RDSR = 2'd3
  } xfer_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } seq_state_t;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs #(
  parameter int NUM_PRG = 6,
  parameter int CNT_W   = 8,
  localparam int PRG_IDX_W = $clog2(NUM_PRG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prg_we,
  input  logic [PRG_IDX_W-1:0]   prg_idx,
  input  logic [7:0]             prg_wdata,
  input  logic                   cnt_we,
  input  logic [CNT_W-1:0]       cnt_wdata,
  output logic [8*NUM_PRG-1:0]   prg_flat,
  output logic [CNT_W-1:0]       cnt_q
);

  // one byte register per transmit slot, each with its own enable
  for (genvar g = 0; g < NUM_PRG; g++) begin : g_prg
    logic       en;
    logic [7:0] byte_q;

    assign en = prg_we && (prg_idx == PRG_IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (en) begin
        byte_q <= prg_wdata;
      end
    end

    assign prg_flat[8*g +: 8] = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_wdata;
    end
  end

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int         NUM_PRG     = 6,
  parameter int         CNT_W       = 8,
  parameter int         SCK_HALF    = 2,
  parameter logic [7:0] RDSR_OPCODE = 8'h05,
  localparam int MAX_BITS = (NUM_PRG + 1) * 8,
  localparam int NB_W     = $clog2(MAX_BITS + 1),
  localparam int HC_W     = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_we,
  input  logic [7:0]            cmd_code,
  input  logic [8*NUM_PRG-1:0]  prg_flat,
  input  logic [CNT_W-1:0]      cnt_q,
  input  logic                  miso,
  output logic                  sck,
  output logic                  cs_n,
  output logic                  mosi,
  output logic                  busy,
  output logic                  done,
  output xfer_kind_t            done_kind,
  output logic [MAX_BITS-1:0]   rx_vec
);

  seq_state_t            state_q, state_d;
  xfer_kind_t            kind_q, kind_d;
  xfer_kind_t            dkind_q, dkind_d;
  logic [MAX_BITS-1:0]   tx_q, tx_d;
  logic [MAX_BITS-1:0]   rx_q, rx_d;
  logic [NB_W-1:0]       bits_q, bits_d;
  logic [HC_W-1:0]       half_q, half_d;
  logic                  sck_q, sck_d;
  logic                  cs_n_q, cs_n_d;
  logic                  mosi_q, mosi_d;
  logic                  done_q, done_d;

  // command decode and transmit snapshot
  logic [NB_W-1:0]       eff_cnt;
  xfer_kind_t            start_kind;
  logic [MAX_BITS-1:0]   start_vec;
  logic [NB_W-1:0]       start_bits;
  logic                  half_end;

  always_comb begin
    if (cnt_q > CNT_W'(MAX_BITS)) begin
      eff_cnt = NB_W'(MAX_BITS);
    end else begin
      eff_cnt = cnt_q[NB_W-1:0];
    end
  end

  always_comb begin
    start_kind = XF_NONE;
    start_vec  = '0;
    start_bits = '0;
    if (cmd_we && (state_q == ST_IDLE)) begin
      unique case (cmd_code)
        CMD_PROG: begin
          if (eff_cnt != '0) begin
            start_kind = XF_PROG;
            start_vec  = {prg_flat, 8'h00};
            start_bits = eff_cnt;
          end
        end
        CMD_WRSR: begin
          start_kind = XF_WRSR;
          start_vec  = {prg_flat[8*NUM_PRG-1 -: 8], {(MAX_BITS-8){1'b0}}};
          start_bits = NB_W'(8);
        end
        CMD_RDSR: begin
          start_kind = XF_RDSR;
          start_vec  = {RDSR_OPCODE, {(MAX_BITS-8){1'b0}}};
          start_bits = NB_W'(16);
        end
        default: start_kind = XF_NONE;
      endcase
    end
  end

  assign half_end = (half_q == HC_W'(SCK_HALF - 1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    dkind_d = dkind_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    bits_d  = bits_q;
    half_d  = half_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    mosi_d  = mosi_q;
    done_d  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_kind != XF_NONE) begin
          state_d = ST_LEAD;
          kind_d  = start_kind;
          tx_d    = start_vec;
          rx_d    = '0;
          bits_d  = start_bits;
          half_d  = '0;
          cs_n_d  = 1'b0;
          mosi_d  = start_vec[MAX_BITS-1];
        end
      end
      ST_LEAD: begin
        state_d = ST_SHIFT;
        half_d  = '0;
      end
      ST_SHIFT: begin
        if (!sck_q) begin
          if (half_end) begin
            sck_d  = 1'b1;
            half_d = '0;
            rx_d   = {rx_q[MAX_BITS-2:0], miso};
          end else begin
            half_d = half_q + HC_W'(1);
          end
        end else begin
          if (half_end) begin
            sck_d  = 1'b0;
            half_d = '0;
            if (bits_q == NB_W'(1)) begin
              state_d = ST_TRAIL;
              mosi_d  = 1'b0;
            end else begin
              bits_d = bits_q - NB_W'(1);
              tx_d   = {tx_q[MAX_BITS-2:0], 1'b0};
              mosi_d = tx_q[MAX_BITS-2];
            end
          end else begin
            half_d = half_q + HC_W'(1);
          end
        end
      end
      ST_TRAIL: begin
        state_d = ST_IDLE;
        cs_n_d  = 1'b1;
        done_d  = 1'b1;
        dkind_d = kind_q;
        kind_d  = XF_NONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= XF_NONE;
      dkind_q <= XF_NONE;
      tx_q    <= '0;
      rx_q    <= '0;
      bits_q  <= '0;
      half_q  <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      dkind_q <= dkind_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      bits_q  <= bits_d;
      half_q  <= half_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      mosi_q  <= mosi_d;
      done_q  <= done_d;
    end
  end

  assign sck       = sck_q;
  assign cs_n      = cs_n_q;
  assign mosi      = mosi_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign done_kind = dkind_q;
  assign rx_vec    = rx_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck_q); // R8

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && !cs_n_q) |-> $stable(mosi_q)); // R8

  AST_LEAD_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |=> (!cs_n_q && !sck_q)); // R8

  AST_BITS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (bits_q != '0 && bits_q <= NB_W'(MAX_BITS))); // R4

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we && state_q != ST_TRAIL) |=> busy); // R7

  AST_CS_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> done_q); // R7

endmodule

// File: rtl/spi_cmd_rxbank.sv
module spi_cmd_rxbank
  import spi_cmd_pkg::*;
#(
  parameter int NUM_PRG = 6,
  localparam int SH_BYTES = NUM_PRG + 1,
  localparam int MAX_BITS = 8 * SH_BYTES,
  localparam int SH_IDX_W = $clog2(SH_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done,
  input  xfer_kind_t            done_kind,
  input  logic [MAX_BITS-1:0]   rx_vec,
  input  logic [SH_IDX_W-1:0]   rd_idx,
  output logic [7:0]            rd_data,
  output logic [7:0]            status
);

  logic                 cap_prog;
  logic                 cap_stat;
  logic [MAX_BITS-1:0]  bank_flat;

  assign cap_prog = done && (done_kind == XF_PROG);
  assign cap_stat = done && (done_kind == XF_RDSR);

  for (genvar g = 0; g < SH_BYTES; g++) begin : g_bank
    logic [7:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (cap_prog) begin
        byte_q <= rx_vec[8*g +: 8];
      end
    end

    assign bank_flat[8*g +: 8] = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else if (cap_stat) begin
      status <= rx_vec[7:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < SH_BYTES; k++) begin
      if (rd_idx == SH_IDX_W'(k)) begin
        rd_data = bank_flat[8*k +: 8];
      end
    end
  end

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int         NUM_PRG     = 6,
  parameter int         CNT_W       = 8,
  parameter int         SCK_HALF    = 2,
  parameter logic [7:0] RDSR_OPCODE = 8'h05,
  localparam int PRG_IDX_W = $clog2(NUM_PRG),
  localparam int SH_IDX_W  = $clog2(NUM_PRG + 1),
  localparam int MAX_BITS  = (NUM_PRG + 1) * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prg_we,
  input  logic [PRG_IDX_W-1:0]  prg_idx,
  input  logic [7:0]            prg_wdata,
  input  logic                  cnt_we,
  input  logic [CNT_W-1:0]      cnt_wdata,
  input  logic                  cmd_we,
  input  logic [7:0]            cmd_code,
  output logic                  busy,
  input  logic [SH_IDX_W-1:0]   shreg_idx,
  output logic [7:0]            shreg_data,
  output logic [7:0]            status_byte,
  output logic                  sck,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);

  logic [8*NUM_PRG-1:0]  prg_flat;
  logic [CNT_W-1:0]      cnt_q;
  logic                  done;
  xfer_kind_t            done_kind;
  logic [MAX_BITS-1:0]   rx_vec;

  spi_cmd_regs #(
    .NUM_PRG (NUM_PRG),
    .CNT_W   (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .prg_we    (prg_we),
    .prg_idx   (prg_idx),
    .prg_wdata (prg_wdata),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .prg_flat  (prg_flat),
    .cnt_q     (cnt_q)
  );

  spi_cmd_seq #(
    .NUM_PRG     (NUM_PRG),
    .CNT_W       (CNT_W),
    .SCK_HALF    (SCK_HALF),
    .RDSR_OPCODE (RDSR_OPCODE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_code  (cmd_code),
    .prg_flat  (prg_flat),
    .cnt_q     (cnt_q),
    .miso      (miso),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .busy      (busy),
    .done      (done),
    .done_kind (done_kind),
    .rx_vec    (rx_vec)
  );

  spi_cmd_rxbank #(
    .NUM_PRG (NUM_PRG)
  ) u_rxbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .done_kind (done_kind),
    .rx_vec    (rx_vec),
    .rd_idx    (shreg_idx),
    .rd_data   (shreg_data),
    .status    (status_byte)
  );

  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n)); // R7

endmodule

// File: tb/spi_cmd_shifter_tb.sv
module spi_cmd_shifter_tb;

  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       prg_we = 1'b0;
  logic [2:0] prg_idx = '0;
  logic [7:0] prg_wdata = '0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_code = '0;
  logic       busy;
  logic [2:0] shreg_idx = '0;
  logic [7:0] shreg_data, status_byte;
  logic       sck, cs_n, mosi;
  logic       miso = 1'b0;

  int total = 0;
  int bad   = 0;

  logic [7:0]  prg_m [6];
  logic [55:0] bank_m;

  spi_cmd_shifter #(.SCK_HALF(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .prg_we(prg_we), .prg_idx(prg_idx),
    .prg_wdata(prg_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmd_we(cmd_we), .cmd_code(cmd_code), .busy(busy),
    .shreg_idx(shreg_idx), .shreg_data(shreg_data),
    .status_byte(status_byte), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso)
  );

  always #5 clk = ~clk;

  // serial-bus monitor and device model, sampled away from the active edge
  int cyc = 0, t_csfall = 0, t_first = 0, t_rise = 0, t_fall = 0, t_csrise = 0;
  int nbits = 0, ncs = 0, hp_err = 0, pidx = 0;
  logic [63:0] cap = '0, pat = '0;
  bit   first = 1'b0;
  logic prev_cs = 1'b1, prev_sck = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      t_csfall = cyc; nbits = 0; cap = '0; first = 1'b1; pidx = 1; miso = pat[63];
    end
    if (!cs_n && sck && !prev_sck) begin
      if (first) t_first = cyc;
      else if (cyc - t_fall != H) hp_err++;
      first = 1'b0;
      cap = {cap[62:0], mosi};
      nbits++;
      t_rise = cyc;
    end
    if (!cs_n && !sck && prev_sck) begin
      t_fall = cyc;
      if (cyc - t_rise != H) hp_err++;
      miso = (pidx < 64) ? pat[63-pidx] : 1'b0;
      pidx++;
    end
    if (!prev_cs && cs_n) begin
      t_csrise = cyc; ncs++;
    end
    prev_cs = cs_n; prev_sck = sck;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_tx(input logic [55:0] v, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[62:0], v[55-i]};
    return r;
  endfunction

  function automatic logic [55:0] exp_rx(input logic [63:0] p, input int n);
    logic [55:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[54:0], p[63-i]};
    return r;
  endfunction

  function automatic logic [55:0] tx_vec();
    logic [55:0] v;
    for (int k = 0; k < 6; k++) v[8*k+8 +: 8] = prg_m[k];
    v[7:0] = 8'h00;
    return v;
  endfunction

  task automatic write_prg(input int idx, input logic [7:0] val);
    @(negedge clk); prg_we = 1'b1; prg_idx = 3'(idx); prg_wdata = val;
    @(negedge clk); prg_we = 1'b0;
    prg_m[idx] = val;
  endtask

  task automatic write_cnt(input logic [7:0] val);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = val;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic issue(input logic [7:0] code);
    @(negedge clk); cmd_we = 1'b1; cmd_code = code;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_bank(output logic [55:0] v);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); shreg_idx = 3'(k); #1;
      v[8*k +: 8] = shreg_data;
    end
  endtask

  task automatic check_frame(input string req);
    chk(t_first - t_csfall == 1 + H, req, 64'(t_first - t_csfall), 64'(1 + H));
    chk(t_csrise - t_fall == 1, req, 64'(t_csrise - t_fall), 64'd1);
  endtask

  task automatic run_prog(input logic [7:0] cnt, input logic [63:0] p);
    int n;
    int ncs0;
    logic [55:0] bv;
    n = (cnt > 56) ? 56 : int'(cnt);
    write_cnt(cnt);
    pat = p;
    ncs0 = ncs;
    hp_err = 0;
    issue(8'h04);
    chk(busy == (n != 0), "R7 busy after accept", 64'(busy), 64'(n != 0));
    wait_idle();
    read_bank(bv);
    if (n == 0) begin
      chk(ncs == ncs0, "R4 zero count no frame", 64'(ncs), 64'(ncs0));
      chk(bv == bank_m, "R4 zero count bank kept", 64'(bv), 64'(bank_m));
    end else begin
      chk(nbits == n, "R2 R4 bit count", 64'(nbits), 64'(n));
      chk(cap == exp_tx(tx_vec(), n), "R2 mosi bits", cap, exp_tx(tx_vec(), n));
      chk(bv == exp_rx(p, n), "R3 receive bank", 64'(bv), 64'(exp_rx(p, n)));
      check_frame("R8 framing");
      chk(hp_err == 0, "R10 half period", 64'(hp_err), 64'd0);
      bank_m = bv;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [55:0] bv;
    logic [7:0]  oldv, newv, st0;
    int          ncs0;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 6; k++) prg_m[k] = 8'h00;
    bank_m = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0 && mosi == 1'b0 && busy == 1'b0, "R1 reset pins",
        {cs_n, sck, mosi, busy}, 64'b1000);
    rst_n = 1'b1;
    read_bank(bv);
    chk(bv == '0, "R1 reset bank", 64'(bv), 64'd0);
    chk(status_byte == 8'h00, "R1 reset status", 64'(status_byte), 64'd0);

    // directed program transfers
    write_prg(5, 8'h9F);
    run_prog(8'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    write_prg(4, 8'hA5); write_prg(3, 8'h3C);
    run_prog(8'd40, 64'h1234_5678_9ABC_DEF0);
    for (int k = 0; k < 6; k++) write_prg(k, 8'(8'h11 * (k + 1)));
    run_prog(8'd56, 64'hC3A5_0F96_5A3C_E187);
    run_prog(8'd63, 64'h0123_4567_89AB_CDEF);  // R4 saturation
    run_prog(8'd0, 64'hFFFF_0000_FFFF_0000);   // R4 empty
    run_prog(8'd13, 64'hDEAD_BEEF_CAFE_F00D);

    // randomized program transfers
    for (int it = 0; it < 20; it++) begin
      for (int k = 0; k < 6; k++) write_prg(k, 8'($urandom));
      run_prog(8'($urandom_range(1, 56)), {$urandom, $urandom});
    end

    // R5 write status ignores count, keeps bank
    write_cnt(8'd40);
    write_prg(5, 8'h6B);
    pat = 64'hAAAA_AAAA_AAAA_AAAA;
    issue(8'h20);
    wait_idle();
    chk(nbits == 8, "R5 write-status length", 64'(nbits), 64'd8);
    chk(cap[7:0] == 8'h6B, "R5 write-status byte", 64'(cap[7:0]), 64'h6B);
    read_bank(bv);
    chk(bv == bank_m, "R5 bank unchanged", 64'(bv), 64'(bank_m));

    // R6 read status
    pat = 64'h00C7_0000_0000_0000;
    issue(8'h02);
    wait_idle();
    chk(nbits == 16, "R6 read-status length", 64'(nbits), 64'd16);
    chk(cap[15:0] == 16'h0500, "R6 read-status opcode", 64'(cap[15:0]), 64'h0500);
    chk(status_byte == 8'hC7, "R6 status byte", 64'(status_byte), 64'hC7);
    check_frame("R8 framing status");
    read_bank(bv);
    chk(bv == bank_m, "R6 bank unchanged", 64'(bv), 64'(bank_m));

    // R7 command while busy is dropped
    write_cnt(8'd24);
    pat = 64'h5555_5555_5555_5555;
    ncs0 = ncs;
    st0 = status_byte;
    issue(8'h04);
    @(negedge clk); cmd_we = 1'b1; cmd_code = 8'h02;
    @(negedge clk); cmd_we = 1'b0;
    wait_idle();
    repeat (12) @(negedge clk);
    chk(ncs == ncs0 + 1, "R7 one frame only", 64'(ncs), 64'(ncs0 + 1));
    chk(status_byte == st0, "R7 status untouched", 64'(status_byte), 64'(st0));
    read_bank(bv);
    bank_m = bv;

    // R7 unknown code
    ncs0 = ncs;
    issue(8'h11);
    chk(busy == 1'b0, "R7 unknown code idle", 64'(busy), 64'd0);
    repeat (6) @(negedge clk);
    chk(ncs == ncs0, "R7 unknown code no frame", 64'(ncs), 64'(ncs0));

    // R9 same-cycle register write and command
    oldv = prg_m[5];
    newv = ~oldv;
    @(negedge clk);
    prg_we = 1'b1; prg_idx = 3'd5; prg_wdata = newv; cmd_we = 1'b1; cmd_code = 8'h20;
    @(negedge clk);
    prg_we = 1'b0; cmd_we = 1'b0;
    prg_m[5] = newv;
    wait_idle();
    chk(cap[7:0] == oldv, "R9 old byte sent", 64'(cap[7:0]), 64'(oldv));
    issue(8'h20);
    wait_idle();
    chk(cap[7:0] == newv, "R9 new byte next", 64'(cap[7:0]), 64'(newv));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule